// File: doc/BRIEF.md
# Biresidue Syndrome Checker and Single-Error Corrector

This block sits behind an arithmetic datapath whose result word may carry a single arithmetic error. Alongside the possibly faulty result word it receives two check residues of the true value, computed independently: one modulo 7 and one modulo 15. It reduces the word by both moduli and subtracts the check residues to form a two-part syndrome. A zero syndrome means the word is trusted and is sent to the clean output. A non-zero syndrome means an error was detected. The pair is then matched against the residues of every error of the form +2^i or −2^i, and the matching power of two is removed from the word to restore it.

Each accepted word produces one registered result one cycle later. The result carries the syndrome, an error flag and an uncorrectable flag. The data goes to exactly one of two data ports, and the other port reads zero. Both moduli are of the form 2^k−1 with coprime k, so each of the 24 single errors of a 12-bit word has its own syndrome.

Top module: `biresidue_corrector`

## Requirements
- R1: One cycle after an accepted word, out_syn_a equals (N' mod 7 − X) mod 7 and out_syn_b equals (N' mod 15 − Y) mod 15, each taken in the range 0 to modulus−1.
- R2: When both syndrome parts are zero, out_err is 0, out_uncorr is 0, out_clean carries N' unchanged and out_fixed is 0.
- R3: When either syndrome part is non-zero, out_err is 1 and out_clean is 0.
- R4: A syndrome equal to (2^i mod 7, 2^i mod 15) for some i in 0..11 gives out_fixed = (N' − 2^i) mod 4096. A syndrome equal to ((7 − 2^i mod 7) mod 7, (15 − 2^i mod 15) mod 15) gives out_fixed = (N' + 2^i) mod 4096. In both cases out_uncorr is 0.
- R5: A non-zero syndrome that matches none of the 24 entries of R4 sets out_uncorr to 1, and out_fixed carries N' unchanged.
- R6: A check residue input that is all ones (7 on the modulo-7 input, 15 on the modulo-15 input) counts as the residue zero.
- R7: out_valid is in_valid delayed by one clock. While in_valid is low, every output except out_valid keeps its value, whatever in_word and the residue inputs do.
- R8: While rst_n is low, every output is zero.
- R9: A true value of 862 corrupted to 863 (check residues 1 and 7) yields the syndrome (1,1) and out_fixed = 862.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word and residues are accepted this cycle |
| in_word | input | DATA_W (12) | Possibly corrupted result word N' |
| in_res_a | input | RA_BITS (3) | Check residue of the true value modulo 2^RA_BITS−1 |
| in_res_b | input | RB_BITS (4) | Check residue of the true value modulo 2^RB_BITS−1 |
| out_valid | output | 1 | Registered result strobe |
| out_err | output | 1 | Non-zero syndrome detected |
| out_uncorr | output | 1 | Non-zero syndrome matches no single error |
| out_syn_a | output | RA_BITS (3) | Syndrome part modulo 7 |
| out_syn_b | output | RB_BITS (4) | Syndrome part modulo 15 |
| out_clean | output | DATA_W (12) | Word passed through when the syndrome is zero, else 0 |
| out_fixed | output | DATA_W (12) | Corrected word when an error was detected, else 0 |

## Verification
The hard cases are the borders of the correctable set. These are errors on the top bit, where the corrected value sits at 0 or 4095, and syndromes that are non-zero yet absent from the table. Neither of these appears when words come from a normal datapath. The stimulus builds them directly. It picks a true value clear of wrap-around, adds or subtracts each power of two, and presents the residues of the true value. For the uncorrectable case it supplies residues that leave one syndrome part at zero and the other non-zero. No single error can produce such a pair.

// File: rtl/biresidue_pkg.sv
package biresidue_pkg;

   function automatic int gcd_f(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int pow2_mod_exp(input int i, input int k);
      return 1 << (i % k);
   endfunction

endpackage

// File: rtl/residue_fold.sv
module residue_fold #(
   parameter int IN_W = 12,
   parameter int K    = 3
) (
   input  logic [IN_W-1:0] din,
   output logic [K-1:0]    res
);
   localparam int NCH   = (IN_W + K - 1) / K;
   localparam int PAD_W = NCH * K;
   localparam int SUM_W = K + $clog2(NCH + 1) + 1;
   localparam int FOLDS = SUM_W;

   logic [PAD_W-1:0] padded;
   logic [SUM_W-1:0] acc;

   always_comb begin
      padded = '0;
      padded[IN_W-1:0] = din;
      acc = '0;
      for (int c = 0; c < NCH; c++) begin
         acc = acc + SUM_W'(padded[c*K +: K]);
      end
      for (int f = 0; f < FOLDS; f++) begin
         acc = SUM_W'(acc[K-1:0]) + (acc >> K);
      end
      res = (acc[K-1:0] == {K{1'b1}}) ? '0 : acc[K-1:0];
   end
endmodule

// File: rtl/syndrome_unit.sv
module syndrome_unit #(
   parameter int DATA_W = 12,
   parameter int K      = 3
) (
   input  logic [DATA_W-1:0] word,
   input  logic [K-1:0]      chk,
   output logic [K-1:0]      syn
);
   localparam logic [K-1:0] MODV = {K{1'b1}};

   logic [K-1:0] word_res;
   logic [K-1:0] chk_norm;
   logic [K:0]   diff;

   residue_fold #(.IN_W(DATA_W), .K(K)) u_fold (
      .din (word),
      .res (word_res)
   );

   always_comb begin
      chk_norm = (chk == MODV) ? '0 : chk;
      if (word_res >= chk_norm)
         diff = {1'b0, word_res} - {1'b0, chk_norm};
      else
         diff = {1'b0, word_res} + {1'b0, MODV} - {1'b0, chk_norm};
      syn = diff[K-1:0];
   end
endmodule

// File: rtl/error_locator.sv
module error_locator #(
   parameter int DATA_W  = 12,
   parameter int RA_BITS = 3,
   parameter int RB_BITS = 4
) (
   input  logic [RA_BITS-1:0] syn_a,
   input  logic [RB_BITS-1:0] syn_b,
   output logic               hit,
   output logic [DATA_W-1:0]  delta_sub,
   output logic [DATA_W-1:0]  delta_add
);
   import biresidue_pkg::*;

   localparam int MOD_A = (1 << RA_BITS) - 1;
   localparam int MOD_B = (1 << RB_BITS) - 1;

   logic [DATA_W-1:0] match_up;
   logic [DATA_W-1:0] match_dn;

   for (genvar i = 0; i < DATA_W; i++) begin : g_entry
      localparam int UP_A = pow2_mod_exp(i, RA_BITS);
      localparam int UP_B = pow2_mod_exp(i, RB_BITS);
      localparam int DN_A = MOD_A - UP_A;
      localparam int DN_B = MOD_B - UP_B;
      assign match_up[i] = (int'(syn_a) == UP_A) && (int'(syn_b) == UP_B);
      assign match_dn[i] = (int'(syn_a) == DN_A) && (int'(syn_b) == DN_B);
   end

   always_comb begin
      delta_sub = '0;
      delta_add = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (match_up[i]) delta_sub[i] = 1'b1;
         if (match_dn[i]) delta_add[i] = 1'b1;
      end
      hit = (|match_up) | (|match_dn);
   end
endmodule

// File: rtl/biresidue_corrector.sv
module biresidue_corrector #(
   parameter int DATA_W  = 12,
   parameter int RA_BITS = 3,
   parameter int RB_BITS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_word,
   input  logic [RA_BITS-1:0] in_res_a,
   input  logic [RB_BITS-1:0] in_res_b,
   output logic               out_valid,
   output logic               out_err,
   output logic               out_uncorr,
   output logic [RA_BITS-1:0] out_syn_a,
   output logic [RB_BITS-1:0] out_syn_b,
   output logic [DATA_W-1:0]  out_clean,
   output logic [DATA_W-1:0]  out_fixed
);
   import biresidue_pkg::*;

   localparam int COVER = RA_BITS * RB_BITS;

   if (RA_BITS < 2 || RB_BITS < 2) begin : g_bad_width
      $error("residue widths must be at least 2 bits");
   end
   if (gcd_f(RA_BITS, RB_BITS) != 1) begin : g_bad_gcd
      $error("residue widths must be coprime");
   end
   if (DATA_W > COVER) begin : g_bad_cover
      $error("DATA_W exceeds the range with distinct syndromes");
   end

   logic [RA_BITS-1:0] syn_a;
   logic [RB_BITS-1:0] syn_b;
   logic               hit;
   logic [DATA_W-1:0]  delta_sub;
   logic [DATA_W-1:0]  delta_add;
   logic               err_c;
   logic [DATA_W-1:0]  repaired;
   logic [DATA_W-1:0]  clean_c;
   logic [DATA_W-1:0]  fixed_c;

   syndrome_unit #(.DATA_W(DATA_W), .K(RA_BITS)) u_syn_a (
      .word (in_word),
      .chk  (in_res_a),
      .syn  (syn_a)
   );

   syndrome_unit #(.DATA_W(DATA_W), .K(RB_BITS)) u_syn_b (
      .word (in_word),
      .chk  (in_res_b),
      .syn  (syn_b)
   );

   error_locator #(.DATA_W(DATA_W), .RA_BITS(RA_BITS), .RB_BITS(RB_BITS)) u_loc (
      .syn_a     (syn_a),
      .syn_b     (syn_b),
      .hit       (hit),
      .delta_sub (delta_sub),
      .delta_add (delta_add)
   );

   always_comb begin
      err_c    = (|syn_a) | (|syn_b);
      repaired = in_word - delta_sub + delta_add;
      clean_c  = err_c ? '0 : in_word;
      fixed_c  = !err_c ? '0 : (hit ? repaired : in_word);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_err    <= 1'b0;
         out_uncorr <= 1'b0;
         out_syn_a  <= '0;
         out_syn_b  <= '0;
         out_clean  <= '0;
         out_fixed  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_err    <= err_c;
            out_uncorr <= err_c & ~hit;
            out_syn_a  <= syn_a;
            out_syn_b  <= syn_b;
            out_clean  <= clean_c;
            out_fixed  <= fixed_c;
         end
      end
   end
endmodule

// File: rtl/biresidue_corrector_chk.sv
module biresidue_corrector_chk #(
   parameter int DATA_W  = 12,
   parameter int RA_BITS = 3,
   parameter int RB_BITS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [DATA_W-1:0]  in_word,
   input logic               out_valid,
   input logic               out_err,
   input logic               out_uncorr,
   input logic [RA_BITS-1:0] out_syn_a,
   input logic [RB_BITS-1:0] out_syn_b,
   input logic [DATA_W-1:0]  out_clean,
   input logic [DATA_W-1:0]  out_fixed
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_valid == $past(in_valid))); // R7

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(in_valid)) |-> ($stable(out_clean) && $stable(out_fixed) && $stable(out_err))); // R7

   AST_QUIET_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err) |-> (out_syn_a == '0 && out_syn_b == '0 && out_fixed == '0 && !out_uncorr)); // R2

   AST_CLEAN_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && out_valid && !out_err) |-> (out_clean == $past(in_word))); // R2

   AST_FLAG_ON_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_syn_a != '0 || out_syn_b != '0)) |-> (out_err && out_clean == '0)); // R3

   AST_UNCORR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && out_valid && out_uncorr) |-> (out_err && out_fixed == $past(in_word))); // R5
endmodule

bind biresidue_corrector biresidue_corrector_chk #(
   .DATA_W(DATA_W), .RA_BITS(RA_BITS), .RB_BITS(RB_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_word    (in_word),
   .out_valid  (out_valid),
   .out_err    (out_err),
   .out_uncorr (out_uncorr),
   .out_syn_a  (out_syn_a),
   .out_syn_b  (out_syn_b),
   .out_clean  (out_clean),
   .out_fixed  (out_fixed)
);

// File: tb/sim_biresidue_corrector.sv
module sim_biresidue_corrector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] in_word = '0;
   logic [2:0]  in_res_a = '0;
   logic [3:0]  in_res_b = '0;
   logic        out_valid, out_err, out_uncorr;
   logic [2:0]  out_syn_a;
   logic [3:0]  out_syn_b;
   logic [11:0] out_clean, out_fixed;

   always #5 clk = ~clk;

   biresidue_corrector u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_res_a(in_res_a), .in_res_b(in_res_b), .out_valid(out_valid),
      .out_err(out_err), .out_uncorr(out_uncorr), .out_syn_a(out_syn_a),
      .out_syn_b(out_syn_b), .out_clean(out_clean), .out_fixed(out_fixed)
   );

   int    compared = 0;
   int    mismatched = 0;
   bit    done = 1'b0;
   bit    running = 1'b0;
   string cur_req = "R2";

   int    e_valid = 0, e_err = 0, e_unc = 0, e_sa = 0, e_sb = 0, e_clean = 0, e_fixed = 0;
   string e_req = "R8";

   function automatic void ref_eval(input int n, input int x, input int y,
                                    output int sa, output int sb, output int err,
                                    output int unc, output int clean, output int fixed);
      int xa, yb, found, p;
      xa = (x == 7) ? 0 : x;
      yb = (y == 15) ? 0 : y;
      sa = ((n % 7) - xa + 7) % 7;
      sb = ((n % 15) - yb + 15) % 15;
      err = (sa != 0 || sb != 0) ? 1 : 0;
      found = 0;
      fixed = 0;
      clean = err ? 0 : n;
      if (err) begin
         fixed = n;
         for (int i = 0; i < 12; i++) begin
            p = 1 << i;
            if (sa == p % 7 && sb == p % 15) begin
               fixed = (n - p + 4096) % 4096; found = 1;
            end
            if (sa == (7 - p % 7) % 7 && sb == (15 - p % 15) % 15) begin
               fixed = (n + p) % 4096; found = 1;
            end
         end
      end
      unc = (err && !found) ? 1 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid = 0; e_err = 0; e_unc = 0; e_sa = 0; e_sb = 0; e_clean = 0; e_fixed = 0;
      end else begin
         e_valid = in_valid;
         if (in_valid) begin
            ref_eval(int'(in_word), int'(in_res_a), int'(in_res_b),
                     e_sa, e_sb, e_err, e_unc, e_clean, e_fixed);
            e_req = cur_req;
         end
      end
   end

   task automatic cmp(input string req, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string req);
      cmp("R7", "out_valid", int'(out_valid), e_valid);
      cmp("R1", "out_syn_a", int'(out_syn_a), e_sa);
      cmp("R1", "out_syn_b", int'(out_syn_b), e_sb);
      cmp(req, "out_err", int'(out_err), e_err);
      cmp(req, "out_uncorr", int'(out_uncorr), e_unc);
      cmp(req, "out_clean", int'(out_clean), e_clean);
      cmp(req, "out_fixed", int'(out_fixed), e_fixed);
   endtask

   always @(negedge clk) begin
      if (running && rst_n) compare_all(e_req);
   end

   task automatic send(input int n, input int x, input int y, input string req);
      @(negedge clk);
      cur_req = req;
      in_valid = 1'b1;
      in_word = 12'(n);
      in_res_a = 3'(x);
      in_res_b = 4'(y);
   endtask

   task automatic idle(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_word = 12'($urandom);
         in_res_a = 3'($urandom);
         in_res_b = 4'($urandom);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      int v, n;
      repeat (3) @(negedge clk);
      // R8: outputs during reset
      cmp("R8", "out_valid", int'(out_valid), 0);
      cmp("R8", "out_err", int'(out_err), 0);
      cmp("R8", "out_clean", int'(out_clean), 0);
      cmp("R8", "out_fixed", int'(out_fixed), 0);
      cmp("R8", "out_syn_b", int'(out_syn_b), 0);
      rst_n = 1'b1;
      running = 1'b1;

      // R2: clean words
      for (int k = 0; k < 20; k++) begin
         v = int'($urandom % 4096);
         send(v, v % 7, v % 15, "R2");
      end
      send(0, 0, 0, "R2");
      send(4095, 4095 % 7, 4095 % 15, "R2");
      // R6: all-ones residue encodes zero
      send(0, 7, 15, "R6");
      send(105, 7, 15, "R6");
      send(210, 7, 0, "R6");
      send(14, 0, 14, "R6");
      // R9: worked example
      send(863, 1, 7, "R9");
      idle(1);
      // R4: every single error, both signs
      for (int i = 0; i < 12; i++) begin
         v = int'($urandom % (4096 - (1 << i)));
         send(v + (1 << i), v % 7, v % 15, "R4");
         v = (1 << i) + int'($urandom % (4096 - (1 << i)));
         send(v - (1 << i), v % 7, v % 15, "R4");
      end
      send(2048, 0, 0, "R4");
      send(2047, 4095 % 7, 4095 % 15, "R4");
      // R5: syndromes outside the table
      for (int k = 0; k < 8; k++) begin
         n = int'($urandom % 4096);
         send(n, n % 7, (n % 15 + 1 + k) % 15, "R5");
         send(n, (n % 7 + 1 + (k % 6)) % 7, n % 15, "R5");
      end
      // R7: gaps with changing inputs, then back-to-back
      idle(4);
      send(100, 2, 10, "R7");
      idle(3);
      send(1234, 1234 % 7, 1234 % 15, "R7");
      send(1235, 1234 % 7, 1234 % 15, "R7");
      idle(5);
      // R3: mixed random errors
      for (int k = 0; k < 40; k++) begin
         n = int'($urandom % 4096);
         send(n, int'($urandom % 8), int'($urandom % 16), "R3");
      end
      idle(3);
      @(negedge clk);
      running = 1'b0;
      finish_run();
   end
endmodule